// File: doc/BRIEF.md
# Strap Latch and Clock Mode Selector

This block sits in a clock generator and decides, once per power-up, how every clock output should behave. While power-on reset is held it samples three strap pins: an active-low output-disable strap and a two-bit frequency code. It keeps that sample for the rest of the session, so the same pins can later carry clock signals without disturbing the choice. From the held code it selects one of three operating modes. In the output-off mode every output is parked low with its enable cleared. In the test mode each output is derived from a test clock by fixed division. In the run mode the block reports the CPU frequency choice as a select code for the divider network.

In the run mode the block also drives the memory clock. It picks between two ideal source clocks, a 100 MHz one and a 133 MHz one. Software may ask for the faster memory clock, but the block grants that request only when the held straps choose the 133 MHz CPU clock. Handover between the sources is glitch-free. The old source is gated off only while it is low. A two-stage synchronizer then passes the handover to the new path. The new source is gated on only while it is low. The CPU select and the mode outputs do not move during the change.

Top module: `strap_mode_ctrl`

## Requirements
- R1: Strap capture. The straps are sampled on every clock edge while `rst` is high, and the last such sample is held. Changes on the strap pins after reset have no effect on `op_mode`, `cpu_sel` or `out_oe`.
- R2: Output-off mode. A held `strap_tri_n` of 0 gives `op_mode`=0 and `cpu_sel`=3, whatever the value of `strap_fs`. In this mode `out_oe`=0 and `sdram_clk`, `tst_clk` and `tst_ref` all stay 0.
- R3: Test mode. A held `strap_tri_n`=1 with `strap_fs`=00 gives `op_mode`=1, `cpu_sel`=3 and `out_oe`=1.
- R4: Test division. In test mode a counter counts the rising edges of `tclk`. It runs modulo 6, starts at 0 after reset, and advances on the second clock edge after `tclk` is first sampled high. Each output is high while the count modulo its divisor is at least half that divisor: `tst_clk[0]` uses divisor 2, `tst_clk[1]` uses 3 and `tst_clk[2]` uses 6. `tst_ref` equals `tclk` delayed by one clock. Outside test mode all of these outputs are 0.
- R5: Run-mode decode. With `strap_tri_n`=1 and a nonzero `strap_fs`, `op_mode`=2 and `out_oe`=1. `cpu_sel` is `strap_fs` minus 1: 0 selects 66.6 MHz, 1 selects 100 MHz and 2 selects 133 MHz.
- R6: Default memory clock. In run mode with no request, `sdram_fast`=0 and `sdram_clk` is built from whole high phases of `src100`.
- R7: Qualified request. The block moves to `src133` and sets `sdram_fast`=1 only when `sdr133_req`=1 and `cpu_sel`=2. With any other `cpu_sel` the request is ignored.
- R8: Glitch-free handover. Every high phase of `sdram_clk` is one complete high phase of the selected source, taken as the source delayed by one clock. The two sources are never selected at the same time. `cpu_sel` and `op_mode` stay stable throughout the change.
- R9: Release. When `sdr133_req` is cleared, the block returns to `src100` and `sdram_fast` goes back to 0.
- R10: Reset state. While `rst` is high, `sdram_clk`, `sdram_fast`, `tst_clk` and `tst_ref` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset; straps are sampled while it is high |
| strap_fs | input | 2 | Frequency-select strap pins |
| strap_tri_n | input | 1 | Active-low output-disable strap |
| sdr133_req | input | 1 | Register bit requesting the 133 MHz memory clock |
| tclk | input | 1 | Test clock, sampled as a level |
| src100 | input | 1 | Ideal 100 MHz memory source clock, sampled as a level |
| src133 | input | 1 | Ideal 133 MHz memory source clock, sampled as a level |
| op_mode | output | 2 | 0 output-off, 1 test, 2 run |
| out_oe | output | 1 | Output enable for all clock buffers |
| cpu_sel | output | 2 | CPU divider select: 0 = 66.6, 1 = 100, 2 = 133, 3 = test division |
| sdram_fast | output | 1 | The memory clock is currently taken from the 133 MHz source |
| sdram_clk | output | 1 | Gated memory clock |
| tst_clk | output | 3 | Test-mode clocks: divide by 2, 3 and 6 |
| tst_ref | output | 1 | Test-mode reference output, equal to the test clock |

## Verification
The bench runs the block through every strap class: output-off with a nonzero frequency code, test mode, and each of the three run codes. This shows that the disable strap takes priority, and that the all-zero code selects test mode rather than a CPU frequency. The faster memory clock is requested in two cases. In the 100 MHz CPU mode the request must be ignored. In the 133 MHz mode it is set and then cleared, which exercises both handover directions. Every high phase of the memory clock is measured: a length of 4 cycles belongs to the slow source and a length of 3 to the fast one, so any truncated or merged pulse shows up as a wrong length. Toggling the straps after reset separates a held value from a live one.

// File: rtl/strapmode_pkg.sv
package strapmode_pkg;

    typedef enum logic [1:0] {
        OPM_HIZ  = 2'd0,
        OPM_TEST = 2'd1,
        OPM_RUN  = 2'd2
    } opmode_e;

    typedef enum logic [1:0] {
        CPUF_66   = 2'd0,
        CPUF_100  = 2'd1,
        CPUF_133  = 2'd2,
        CPUF_TDIV = 2'd3
    } cpufreq_e;

    typedef struct packed {
        logic       tri_n;
        logic [1:0] fs;
    } strap_t;

    typedef struct packed {
        opmode_e  mode;
        cpufreq_e cpu;
        logic     oe;
    } modesel_t;

    localparam int STRAP_W = $bits(strap_t);

    // The disable strap outranks the frequency code; code 00 means test division.
    function automatic modesel_t decode_strap(strap_t s);
        modesel_t d;
        d.oe = s.tri_n;
        if (!s.tri_n) begin
            d.mode = OPM_HIZ;
            d.cpu  = CPUF_TDIV;
        end else if (s.fs == 2'b00) begin
            d.mode = OPM_TEST;
            d.cpu  = CPUF_TDIV;
        end else begin
            d.mode = OPM_RUN;
            d.cpu  = cpufreq_e'(s.fs - 2'd1);
        end
        return d;
    endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import strapmode_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  strap_t pins,
    output strap_t held
);
    // Follows the pins only while reset is high; frozen afterwards.
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= pins;
        end
    end
endmodule

// File: rtl/mode_decode.sv
module mode_decode
    import strapmode_pkg::*;
(
    input  strap_t   held,
    input  logic     fast_req,
    output modesel_t sel,
    output logic     want_fast
);
    always_comb begin
        sel       = decode_strap(held);
        want_fast = fast_req && (sel.mode == OPM_RUN) && (sel.cpu == CPUF_133);
    end
endmodule

// File: rtl/test_divider.sv
module test_divider #(
    parameter int DIV_A = 2,
    parameter int DIV_B = 3,
    parameter int DIV_C = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tclk,
    output logic [2:0] div_o,
    output logic       ref_o
);
    localparam int CNT_W = $clog2(DIV_C);
    localparam logic [2:0][7:0] DIVS = {8'(DIV_C), 8'(DIV_B), 8'(DIV_A)};

    logic [CNT_W-1:0] cnt;
    logic             t_q;
    logic             t_q2;
    logic             t_rise;

    assign t_rise = t_q & ~t_q2;

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q  <= 1'b0;
            t_q2 <= 1'b0;
        end else begin
            t_q  <= tclk;
            t_q2 <= t_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (t_rise) begin
            cnt <= (cnt == CNT_W'(DIV_C - 1)) ? '0 : cnt + CNT_W'(1);
        end
    end

    for (genvar g = 0; g < 3; g++) begin : g_div
        logic [CNT_W-1:0] rem;
        assign rem      = cnt % CNT_W'(DIVS[g]);
        assign div_o[g] = run && (rem >= CNT_W'(DIVS[g] >> 1));
    end

    assign ref_o = run & t_q;
endmodule

// File: rtl/sdram_clk_switch.sv
module sdram_clk_switch #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic want_fast,
    input  logic src_slow,
    input  logic src_fast,
    output logic clk_o,
    output logic sel_slow,
    output logic sel_fast
);
    localparam int LAST = SYNC - 1;

    logic [SYNC-1:0] ch_s;
    logic [SYNC-1:0] ch_f;
    logic            q_s;
    logic            q_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_s     <= '0;
            ch_f     <= '0;
            q_s      <= 1'b0;
            q_f      <= 1'b0;
            sel_slow <= 1'b0;
            sel_fast <= 1'b0;
        end else begin
            q_s  <= src_slow;
            q_f  <= src_fast;
            ch_s <= {ch_s[SYNC-2:0], active & ~want_fast & ~sel_fast};
            ch_f <= {ch_f[SYNC-2:0], active &  want_fast & ~sel_slow};
            // A gate only moves while its own source sits low.
            if (!q_s) begin
                sel_slow <= ch_s[LAST] & (sel_slow | (~sel_fast & ~ch_f[LAST]));
            end
            if (!q_f) begin
                sel_fast <= ch_f[LAST] & (sel_fast | (~sel_slow & ~ch_s[LAST]));
            end
        end
    end

    assign clk_o = (sel_slow & q_s) | (sel_fast & q_f);
endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
    import strapmode_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TDIV_A      = 2,
    parameter int TDIV_B      = 3,
    parameter int TDIV_C      = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] strap_fs,
    input  logic       strap_tri_n,
    input  logic       sdr133_req,
    input  logic       tclk,
    input  logic       src100,
    input  logic       src133,
    output logic [1:0] op_mode,
    output logic       out_oe,
    output logic [1:0] cpu_sel,
    output logic       sdram_fast,
    output logic       sdram_clk,
    output logic [2:0] tst_clk,
    output logic       tst_ref
);
    strap_t   pins;
    strap_t   held;
    modesel_t msel;
    logic     want_fast;
    logic     sel_slow;

    assign pins = {strap_tri_n, strap_fs};

    strap_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .pins (pins),
        .held (held)
    );

    mode_decode u_dec (
        .held      (held),
        .fast_req  (sdr133_req),
        .sel       (msel),
        .want_fast (want_fast)
    );

    test_divider #(
        .DIV_A (TDIV_A),
        .DIV_B (TDIV_B),
        .DIV_C (TDIV_C)
    ) u_tdiv (
        .clk   (clk),
        .rst   (rst),
        .run   (msel.mode == OPM_TEST),
        .tclk  (tclk),
        .div_o (tst_clk),
        .ref_o (tst_ref)
    );

    sdram_clk_switch #(
        .SYNC (SYNC_STAGES)
    ) u_sw (
        .clk       (clk),
        .rst       (rst),
        .active    (msel.mode == OPM_RUN),
        .want_fast (want_fast),
        .src_slow  (src100),
        .src_fast  (src133),
        .clk_o     (sdram_clk),
        .sel_slow  (sel_slow),
        .sel_fast  (sdram_fast)
    );

    assign op_mode = msel.mode;
    assign cpu_sel = msel.cpu;
    assign out_oe  = msel.oe;
endmodule

// File: rtl/strapmode_chk.sv
module strapmode_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] op_mode,
    input logic       out_oe,
    input logic [1:0] cpu_sel,
    input logic       sdram_fast,
    input logic       sdram_clk,
    input logic [2:0] tst_clk,
    input logic       tst_ref,
    input logic       src100,
    input logic       src133,
    input logic       sel_slow
);
    p_strap_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(op_mode) && $stable(cpu_sel) && $stable(out_oe)));

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 2'd0) |-> (!out_oe && !sdram_clk && tst_clk == 3'b000 && !tst_ref));

    p_test_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (op_mode != 2'd1) |-> (tst_clk == 3'b000 && !tst_ref));

    p_run_code_r5: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 2'd2) |-> (cpu_sel != 2'd3 && out_oe));

    p_fast_qual_r7: assert property (@(posedge clk) disable iff (rst)
        sdram_fast |-> (op_mode == 2'd2 && cpu_sel == 2'd2));

    p_one_source_r8: assert property (@(posedge clk) disable iff (rst)
        !(sel_slow && sdram_fast));

    p_pulse_src_r8: assert property (@(posedge clk) disable iff (rst)
        sdram_clk |-> ((sdram_fast && $past(src133)) || (sel_slow && $past(src100))));
endmodule

bind strap_mode_ctrl strapmode_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_mode    (op_mode),
    .out_oe     (out_oe),
    .cpu_sel    (cpu_sel),
    .sdram_fast (sdram_fast),
    .sdram_clk  (sdram_clk),
    .tst_clk    (tst_clk),
    .tst_ref    (tst_ref),
    .src100     (src100),
    .src133     (src133),
    .sel_slow   (sel_slow)
);

// File: tb/tb_strap_mode_ctrl.sv
`timescale 1ns/1ps
module tb_strap_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] strap_fs = 2'b00;
    logic       strap_tri_n = 1'b1;
    logic       sdr133_req = 1'b0;
    logic       tclk = 1'b0;
    logic       src100 = 1'b0;
    logic       src133 = 1'b0;
    logic [1:0] op_mode;
    logic       out_oe;
    logic [1:0] cpu_sel;
    logic       sdram_fast;
    logic       sdram_clk;
    logic [2:0] tst_clk;
    logic       tst_ref;

    strap_mode_ctrl dut (
        .clk(clk), .rst(rst), .strap_fs(strap_fs), .strap_tri_n(strap_tri_n),
        .sdr133_req(sdr133_req), .tclk(tclk), .src100(src100), .src133(src133),
        .op_mode(op_mode), .out_oe(out_oe), .cpu_sel(cpu_sel), .sdram_fast(sdram_fast),
        .sdram_clk(sdram_clk), .tst_clk(tst_clk), .tst_ref(tst_ref)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference state
    logic [2:0] m_strap;
    bit  m_valid = 0;
    int  m_tq = 0, m_tq2 = 0, m_cnt = 0;
    int  m_q100 = 0, m_q133 = 0;
    int  ph8 = 0, ph6 = 0, tph = 0;
    int  run_len = 0, run_fast = 0, pulses = 0;

    function automatic int exp_mode(input logic [2:0] s);
        if (!s[2]) return 0;
        if (s[1:0] == 2'b00) return 1;
        return 2;
    endfunction

    function automatic int exp_cpu(input logic [2:0] s);
        if (exp_mode(s) != 2) return 3;
        return int'(s[1:0]) - 1;
    endfunction

    always @(posedge clk) begin
        m_q100 <= int'(src100);
        m_q133 <= int'(src133);
        if (rst) begin
            m_strap <= {strap_tri_n, strap_fs};
            m_valid <= 1;
            m_tq    <= 0;
            m_tq2   <= 0;
            m_cnt   <= 0;
        end else begin
            m_tq  <= int'(tclk);
            m_tq2 <= m_tq;
            if (exp_mode(m_strap) != 1) m_cnt <= 0;
            else if (m_tq == 1 && m_tq2 == 0) m_cnt <= (m_cnt + 1) % 6;
        end
    end

    always @(negedge clk) begin
        if (m_valid && !done) begin
            int em;
            em = exp_mode(m_strap);
            chk("R3", "op_mode", int'(op_mode), em);
            chk("R5", "cpu_sel", int'(cpu_sel), exp_cpu(m_strap));
            chk("R2", "out_oe", int'(out_oe), (em != 0) ? 1 : 0);
            chk("R4", "tst_clk0", int'(tst_clk[0]), (em == 1 && (m_cnt % 2) >= 1) ? 1 : 0);
            chk("R4", "tst_clk1", int'(tst_clk[1]), (em == 1 && (m_cnt % 3) >= 1) ? 1 : 0);
            chk("R4", "tst_clk2", int'(tst_clk[2]), (em == 1 && (m_cnt % 6) >= 3) ? 1 : 0);
            chk("R4", "tst_ref", int'(tst_ref), (em == 1) ? m_tq : 0);
            if (rst || em != 2) begin
                if (!rst) chk("R2", "sdram_clk idle", int'(sdram_clk), 0);
                run_len = 0;
            end else if (sdram_clk) begin
                if (run_len == 0) begin
                    run_fast = int'(sdram_fast);
                    chk("R8", "pulse source high", (run_fast != 0) ? m_q133 : m_q100, 1);
                end
                run_len++;
            end else if (run_len > 0) begin
                chk("R8", "high phase length", run_len, (run_fast != 0) ? 3 : 4);
                pulses++;
                run_len = 0;
            end
        end
        // drive sources and test clock away from the active edge
        ph8 = (ph8 + 1) % 8;
        ph6 = (ph6 + 1) % 6;
        tph = (tph + 1) % 4;
        src100 = (ph8 < 4);
        src133 = (ph6 < 3);
        tclk   = (tph < 2);
    end

    task automatic do_reset(input logic tri_n, input logic [1:0] fs);
        @(negedge clk);
        rst = 1'b1;
        strap_tri_n = tri_n;
        strap_fs = fs;
        repeat (3) @(negedge clk);
        // R10: quiet outputs while reset is held
        chk("R10", "sdram_clk in reset", int'(sdram_clk), 0);
        chk("R10", "sdram_fast in reset", int'(sdram_fast), 0);
        chk("R10", "tst_clk in reset", int'(tst_clk), 0);
        chk("R10", "tst_ref in reset", int'(tst_ref), 0);
        rst = 1'b0;
        pulses = 0;
    endtask

    initial begin
        // output-off mode with a nonzero frequency code
        do_reset(1'b0, 2'b11);
        repeat (40) @(negedge clk);
        chk("R2", "op_mode off", int'(op_mode), 0);
        chk("R2", "cpu_sel off", int'(cpu_sel), 3);

        // test mode
        do_reset(1'b1, 2'b00);
        repeat (120) @(negedge clk);
        chk("R3", "op_mode test", int'(op_mode), 1);
        chk("R3", "cpu_sel test", int'(cpu_sel), 3);

        // run 66.6
        do_reset(1'b1, 2'b01);
        repeat (60) @(negedge clk);
        chk("R5", "cpu_sel 66", int'(cpu_sel), 0);
        chk("R6", "slow default", int'(sdram_fast), 0);
        chk("R6", "pulses seen", (pulses > 3) ? 1 : 0, 1);

        // run 100 with request: ignored
        sdr133_req = 1'b1;
        do_reset(1'b1, 2'b10);
        repeat (100) @(negedge clk);
        chk("R5", "cpu_sel 100", int'(cpu_sel), 1);
        chk("R7", "request ignored", int'(sdram_fast), 0);
        sdr133_req = 1'b0;

        // run 133: switch up and down
        do_reset(1'b1, 2'b11);
        repeat (60) @(negedge clk);
        chk("R6", "slow at 133 cpu", int'(sdram_fast), 0);
        sdr133_req = 1'b1;
        repeat (80) @(negedge clk);
        chk("R7", "fast granted", int'(sdram_fast), 1);
        chk("R8", "cpu_sel steady", int'(cpu_sel), 2);
        sdr133_req = 1'b0;
        repeat (80) @(negedge clk);
        chk("R9", "back to slow", int'(sdram_fast), 0);

        // R1: toggle the straps after reset; held value must not move
        strap_tri_n = 1'b0;
        strap_fs = 2'b00;
        repeat (30) @(negedge clk);
        chk("R1", "op_mode held", int'(op_mode), 2);
        chk("R1", "cpu_sel held", int'(cpu_sel), 2);
        strap_fs = 2'b01;
        strap_tri_n = 1'b1;
        repeat (30) @(negedge clk);
        chk("R1", "cpu_sel still held", int'(cpu_sel), 2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule